// File: doc/BRIEF.md
# Lockable RNG control register

This block is the 32-bit control register of a random number generator. It holds the configuration fields of the entropy source and the conditioning stage, a clock-division exponent, the enable and interrupt-enable bits, and a lock. The lock can be set once and is then held. Software writes the register with a single write strobe and full-word data, and reads it with a read strobe.

Three rules gate a configuration write. The lock must be clear. The conditioning soft-reset bit must be set in the same write. For the divider field, the enable bit must also be clear.

Setting the soft-reset bit asserts a reset in the bus domain at once. A two-flop synchronizer carries the request into the RNG clock domain. The RNG side acknowledges it back through a second two-flop synchronizer, using a four-phase handshake. The bit reads back as 1 until that handshake has fully returned to idle. The RNG side also has a divider that produces one tick every 2^N RNG clocks, where N is the divider field.

Top module: `rng_ctrl_reg`

## Requirements
- R1: After rst_ni the register reads 0x0080_0000. Bits 29:26, 7:6 and 1:0 always read 0. rdata_o is 0 when rd_en_i is low.
- R2: The lock (bit 31) goes to 1 on any write with bit 31 set. No write clears it; only rst_ni returns it to 0.
- R3: While the lock is 1, writes to bits 29:4 leave those bits unchanged. These are cfg1 at 25:20, the divider at 19:16, cfg2 at 15:13, nist at 12, cfg3 at 11:8 and ced at 5. Interrupt enable (bit 3) and enable (bit 2) are still written.
- R4: cfg1, cfg2, cfg3 and the divider take new values only from a write that has bit 30 set while the lock is 0. nist and ced take new values from any write while the lock is 0.
- R5: A divider write is ignored if the enable bit was 1 before that write. The decision uses the value before the write, so one write can both set enable and load the divider.
- R6: div_exp_o equals the divider field N. Once N has settled in the RNG domain, div_tick_o is high for one RNG clock in every 2^N.
- R7: Writing bit 30 as 1 raises crst_bus_o on the next bus clock. A synchronizer then raises crst_rng_o in the RNG domain. The other fields of the register are not changed by the soft reset itself. crst_bus_o always equals read-back bit 30.
- R8: After bit 30 is written back to 0, it reads 1 for at least 2 more bus clocks. It drops to 0 once the RNG side has released and acknowledged, within 16 bus clocks when the RNG clock is 7 ns and the bus clock is 4 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| rng_clk_i | input | 1 | Incoming RNG clock |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero without strobe |
| lock_o | output | 1 | Configuration lock |
| en_o | output | 1 | Generator enable |
| ie_o | output | 1 | Interrupt enable |
| ced_o | output | 1 | Clock-error-detect select |
| nist_o | output | 1 | Compliance-mode select |
| cfg1_o | output | 6 | Configuration field 1 |
| cfg2_o | output | 3 | Configuration field 2 |
| cfg3_o | output | 4 | Configuration field 3 |
| div_exp_o | output | 4 | Clock-division exponent N |
| div_tick_o | output | 1 | Divided RNG-clock tick, RNG domain |
| crst_bus_o | output | 1 | Conditioning/FIFO/status reset, bus domain |
| crst_rng_o | output | 1 | Conditioning reset, RNG domain |

## Verification
Some single writes hit two gates at once. One write sets the lock and also commits new configuration under a soft reset. Another sets the enable bit and also loads the divider. In both cases the gates must use the state before the write, so the fields commit together with the new lock or enable bit. The bench issues exactly these combined writes. A behavioural model applies the pre-write rule and is compared with the read-back word on every bus clock. The tick spacing measured afterwards confirms that the divider value was taken.

// File: rtl/rng_ctrl_pkg.sv
`timescale 1ns/1ps
package rng_ctrl_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned LOCK_B   = 31;
  localparam int unsigned CRST_B   = 30;
  localparam int unsigned CFG1_LSB = 20;
  localparam int unsigned CFG1_W   = 6;
  localparam int unsigned DIV_LSB  = 16;
  localparam int unsigned DIV_W    = 4;
  localparam int unsigned CFG2_LSB = 13;
  localparam int unsigned CFG2_W   = 3;
  localparam int unsigned NIST_B   = 12;
  localparam int unsigned CFG3_LSB = 8;
  localparam int unsigned CFG3_W   = 4;
  localparam int unsigned CED_B    = 5;
  localparam int unsigned IE_B     = 3;
  localparam int unsigned EN_B     = 2;

  typedef struct packed {
    logic              lock;
    logic [CFG1_W-1:0] cfg1;
    logic [DIV_W-1:0]  div;
    logic [CFG2_W-1:0] cfg2;
    logic              nist;
    logic [CFG3_W-1:0] cfg3;
    logic              ced;
    logic              ie;
    logic              en;
  } ctl_t;
endpackage

// File: rtl/rng_ctrl_sync.sv
`timescale 1ns/1ps
module rng_ctrl_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rng_ctrl_cfg.sv
`timescale 1ns/1ps
module rng_ctrl_cfg
  import rng_ctrl_pkg::*;
#(
  parameter logic [CFG1_W-1:0] CFG1_RST = 6'h08
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctl_t              ctl_o
);
  localparam ctl_t RST_VAL = '{lock: 1'b0, cfg1: CFG1_RST, div: '0, cfg2: '0,
                               nist: 1'b0, cfg3: '0, ced: 1'b0, ie: 1'b0, en: 1'b0};
  ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= RST_VAL;
    end else if (wr_en_i) begin
      ctl_q.lock <= ctl_q.lock | wdata_i[LOCK_B];
      ctl_q.ie   <= wdata_i[IE_B];
      ctl_q.en   <= wdata_i[EN_B];
      if (!ctl_q.lock) begin
        ctl_q.nist <= wdata_i[NIST_B];
        ctl_q.ced  <= wdata_i[CED_B];
        if (wdata_i[CRST_B]) begin
          ctl_q.cfg1 <= wdata_i[CFG1_LSB +: CFG1_W];
          ctl_q.cfg2 <= wdata_i[CFG2_LSB +: CFG2_W];
          ctl_q.cfg3 <= wdata_i[CFG3_LSB +: CFG3_W];
          // gate on enable as it stood before this write
          if (!ctl_q.en) ctl_q.div <= wdata_i[DIV_LSB +: DIV_W];
        end
      end
    end
  end

  assign ctl_o = ctl_q;

  a_r2_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.lock |=> ctl_q.lock);
  a_r3_locked_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.lock |=> ($stable(ctl_q.cfg1) && $stable(ctl_q.cfg2) && $stable(ctl_q.cfg3)
                    && $stable(ctl_q.div) && $stable(ctl_q.nist) && $stable(ctl_q.ced)));
  a_r4_commit_needs_crst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wdata_i[CRST_B]) |=> ($stable(ctl_q.cfg1) && $stable(ctl_q.cfg2)
                                       && $stable(ctl_q.cfg3) && $stable(ctl_q.div)));
  a_r5_div_frozen_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.en |=> $stable(ctl_q.div));
endmodule

// File: rtl/rng_ctrl_crst.sv
`timescale 1ns/1ps
module rng_ctrl_crst (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rng_clk_i,
  input  logic wr_en_i,
  input  logic crst_wr_i,
  output logic busy_o,
  output logic crst_rng_o
);
  logic sw_q, req_q, ack_s;
  logic req_s, ack_q;

  // bus side: software copy and handshake request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q  <= 1'b0;
      req_q <= 1'b0;
    end else begin
      if (wr_en_i) sw_q <= crst_wr_i;
      if (wr_en_i && crst_wr_i)  req_q <= 1'b1;
      else if (!sw_q && ack_s)   req_q <= 1'b0;
    end
  end

  rng_ctrl_sync #(.W(1), .STAGES(2)) i_req_sync (
    .clk_i(rng_clk_i), .rst_ni(rst_ni), .d_i(req_q), .q_o(req_s));

  always_ff @(posedge rng_clk_i or negedge rst_ni)
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= req_s;

  rng_ctrl_sync #(.W(1), .STAGES(2)) i_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_q), .q_o(ack_s));

  assign busy_o     = sw_q | req_q | ack_s;
  assign crst_rng_o = req_s;

  a_r8_hold_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_q) |-> busy_o);
  a_r7_req_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_s) |=> req_q);
endmodule

// File: rtl/rng_ctrl_div.sv
`timescale 1ns/1ps
module rng_ctrl_div #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             rng_clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = (1 << DIV_W) - 1;

  logic [DIV_W-1:0] div_s;
  logic [CNT_W-1:0] cnt_q, mask;

  // divider is written only while disabled, so a plain multi-bit sync suffices
  rng_ctrl_sync #(.W(DIV_W), .STAGES(2)) i_div_sync (
    .clk_i(rng_clk_i), .rst_ni(rst_ni), .d_i(div_i), .q_o(div_s));

  always_ff @(posedge rng_clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;

  always_comb mask = (CNT_W'(1) << div_s) - CNT_W'(1);

  assign tick_o = (cnt_q & mask) == mask;

  a_r6_no_back_to_back: assert property (@(posedge rng_clk_i) disable iff (!rst_ni)
    (tick_o && div_s != '0) |=> (!tick_o || div_s != $past(div_s)));
endmodule

// File: rtl/rng_ctrl_reg.sv
`timescale 1ns/1ps
module rng_ctrl_reg
  import rng_ctrl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rng_clk_i,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        lock_o,
  output logic        en_o,
  output logic        ie_o,
  output logic        ced_o,
  output logic        nist_o,
  output logic [5:0]  cfg1_o,
  output logic [2:0]  cfg2_o,
  output logic [3:0]  cfg3_o,
  output logic [3:0]  div_exp_o,
  output logic        div_tick_o,
  output logic        crst_bus_o,
  output logic        crst_rng_o
);
  ctl_t              ctl;
  logic              busy;
  logic [DATA_W-1:0] rd_word;

  rng_ctrl_cfg i_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wdata_i(wdata_i), .ctl_o(ctl));

  rng_ctrl_crst i_crst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rng_clk_i(rng_clk_i), .wr_en_i(wr_en_i),
    .crst_wr_i(wdata_i[CRST_B]), .busy_o(busy), .crst_rng_o(crst_rng_o));

  rng_ctrl_div #(.DIV_W(DIV_W)) i_div (
    .rng_clk_i(rng_clk_i), .rst_ni(rst_ni), .div_i(ctl.div), .tick_o(div_tick_o));

  always_comb begin
    rd_word                           = '0;
    rd_word[LOCK_B]                   = ctl.lock;
    rd_word[CRST_B]                   = busy;
    rd_word[CFG1_LSB +: CFG1_W]       = ctl.cfg1;
    rd_word[DIV_LSB +: DIV_W]         = ctl.div;
    rd_word[CFG2_LSB +: CFG2_W]       = ctl.cfg2;
    rd_word[NIST_B]                   = ctl.nist;
    rd_word[CFG3_LSB +: CFG3_W]       = ctl.cfg3;
    rd_word[CED_B]                    = ctl.ced;
    rd_word[IE_B]                     = ctl.ie;
    rd_word[EN_B]                     = ctl.en;
  end

  assign rdata_o    = rd_en_i ? rd_word : '0;
  assign lock_o     = ctl.lock;
  assign en_o       = ctl.en;
  assign ie_o       = ctl.ie;
  assign ced_o      = ctl.ced;
  assign nist_o     = ctl.nist;
  assign cfg1_o     = ctl.cfg1;
  assign cfg2_o     = ctl.cfg2;
  assign cfg3_o     = ctl.cfg3;
  assign div_exp_o  = ctl.div;
  assign crst_bus_o = busy;
endmodule

// File: tb/test_rng_ctrl_reg.sv
`timescale 1ns/1ps
module test_rng_ctrl_reg;
  logic clk = 1'b0, rng_clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b1;
  logic [31:0] wdata = '0, rdata;
  logic lock, en, ie, ced, nist, div_tick, crst_bus, crst_rng;
  logic [5:0] cfg1;
  logic [2:0] cfg2;
  logic [3:0] cfg3, div_exp;

  always #2.0 clk = ~clk;       // 250 MHz
  always #3.5 rng_clk = ~rng_clk;

  rng_ctrl_reg i_rng_ctrl_reg (
    .clk_i(clk), .rst_ni(rst_n), .rng_clk_i(rng_clk), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .lock_o(lock), .en_o(en), .ie_o(ie), .ced_o(ced),
    .nist_o(nist), .cfg1_o(cfg1), .cfg2_o(cfg2), .cfg3_o(cfg3), .div_exp_o(div_exp),
    .div_tick_o(div_tick), .crst_bus_o(crst_bus), .crst_rng_o(crst_rng));

  int checks = 0, errors = 0;
  bit cmp_on = 0, done = 0, rng_seen = 0;

  // behavioural model of the stored fields
  bit m_lock, m_nist, m_ced, m_ie, m_en;
  bit [5:0] m_cfg1;
  bit [3:0] m_div, m_cfg3;
  bit [2:0] m_cfg2;

  function automatic logic [31:0] model_word();
    return {m_lock, 1'b0, 4'b0, m_cfg1, m_div, m_cfg2, m_nist, m_cfg3,
            2'b0, m_ced, 1'b0, m_ie, m_en, 2'b0};
  endfunction

  task automatic model_reset();
    m_lock = 0; m_nist = 0; m_ced = 0; m_ie = 0; m_en = 0;
    m_cfg1 = 6'h08; m_div = 0; m_cfg2 = 0; m_cfg3 = 0;
  endtask

  task automatic model_apply(input logic [31:0] d);
    if (!m_lock) begin
      m_nist = d[12]; m_ced = d[5];
      if (d[30]) begin
        m_cfg1 = d[25:20]; m_cfg2 = d[15:13]; m_cfg3 = d[11:8];
        if (!m_en) m_div = d[19:16];
      end
    end
    m_lock = m_lock | d[31];
    m_ie = d[3]; m_en = d[2];
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && cmp_on && rd_en) begin
    check("R1 R3 R4 R5 word", rdata & ~32'h4000_0000, model_word());
    check("R6 div_exp", {28'b0, div_exp}, {28'b0, m_div});
    check("R7 crst_bus", {31'b0, crst_bus}, {31'b0, rdata[30]});
  end

  always @(posedge rng_clk) if (crst_rng) rng_seen = 1;

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1; wdata = d;
    @(posedge clk); model_apply(d);
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  task automatic crst_cycle(input logic [31:0] d);
    int n;
    rng_seen = 0;
    wr(d | 32'h4000_0000);
    check("R7 bus reset raised", {31'b0, crst_bus}, 32'd1);
    repeat (20) @(negedge clk);
    check("R7 rng reset seen", {31'b0, rng_seen}, 32'd1);
    wr(d & ~32'h4000_0000);
    n = 0;
    while (rdata[30] && n < 100) begin n++; @(negedge clk); end
    check("R8 hold at least 2", {31'b0, n >= 2}, 32'd1);
    check("R8 clear within 16", {31'b0, n <= 16}, 32'd1);
    check("R7 rng reset released", {31'b0, crst_rng}, 32'd0);
  endtask

  task automatic meas(input int n, input string tag);
    int gap;
    repeat (40) @(negedge rng_clk);
    while (!div_tick) @(negedge rng_clk);
    for (int k = 0; k < 3; k++) begin
      gap = 0;
      do begin @(negedge rng_clk); gap++; end while (!div_tick);
      check(tag, gap, 32'd1 << n);
    end
  endtask

  task automatic do_reset();
    cmp_on = 0; rst_n = 0; model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset value", rdata, 32'h0080_0000);
    check("R2 lock clear after reset", {31'b0, lock}, 32'd0);
    cmp_on = 1;
  endtask

  initial begin
    do_reset();
    #1 rd_en = 0; #0.5 check("R1 no strobe reads zero", rdata, 32'h0);
    #0.5 rd_en = 1;
    // R4: no soft reset -> only nist/ced move; reserved bits written as ones
    wr(32'h3FFF_FFE3 & ~32'h4000_0000);
    check("R4 cfg1 held", {26'b0, cfg1}, 32'h08);
    check("R1 reserved zero", rdata & 32'h3C00_00C3, 32'h0);
    // R6: N = 0 and N = 1
    crst_cycle(32'h02A0_5A00);
    meas(0, "R6 gap N=0");
    crst_cycle(32'h0151_2300);
    meas(1, "R6 gap N=1");
    // R5: enable set, divider write ignored
    wr(32'h0000_0004);
    crst_cycle(32'h0014_0004);
    check("R5 div held under enable", {28'b0, div_exp}, 32'd1);
    wr(32'h0000_0000);
    // same write sets enable and loads divider
    crst_cycle(32'h0044_0004);
    check("R5 div loaded with enable", {28'b0, div_exp}, 32'd4);
    meas(4, "R6 gap N=4");
    // same write sets lock and commits config
    crst_cycle(32'h8330_E70C);
    check("R2 lock set", {31'b0, lock}, 32'd1);
    crst_cycle(32'h0000_1020);
    check("R3 cfg1 frozen", {26'b0, cfg1}, 32'h33);
    check("R3 ie/en still written", {30'b0, ie, en}, 32'd0);
    check("R2 lock kept", {31'b0, lock}, 32'd1);
    do_reset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule